// File: doc/BRIEF.md
# Keyed Oscillator Setting Register Bank

This block is a small register slave on a 32-bit memory-mapped bus. It stores the multiplier setting of the programmable oscillator that clocks the processor core and the system bus, and presents the divider fields an oscillator programmer needs: one variable multiplier field and two fixed divider codes. The oscillator output is 48·(M+8)/((R+2)·D) MHz, with the core and bus clock at half of that. At the power-on values of M = 0x20, R = 0x16 and D = 2, this gives 40 MHz at the oscillator and 20 MHz for the core and bus.

Changing the setting takes three steps. First, a key is written to a guard register. Second, the new multiplier is written. It is held as a pending value, while reads and the outputs keep showing the value in force. Third, a soft reset is raised, either by a control-register bit or by an active-low push-button. The soft reset moves the pending value into force and drives a fixed-length reset pulse out to the rest of the system.

Top module: `clkctl_regs`

## Requirements
- R1: After power-on reset the multiplier in force and the pending multiplier are both 0x20, the guard is locked, the guard register reads 0x0001_0000, and the soft-reset output is low.
- R2: The reference-divider output is always 7'h16 and the output-divider code is always 3'b001 (divide by two).
- R3: A write to the guard register at byte offset 0x14 stores the low 16 data bits. It unlocks when those bits equal 0xA05F, and any other value locks. A read returns the stored 16 bits in [15:0], the locked flag in bit 16 (1 = locked), and zero above.
- R4: While locked, a write to the oscillator register is ignored: a later soft reset leaves the multiplier in force unchanged.
- R5: While unlocked, a write to the oscillator register at offset 0x08 stores data bits [7:0] as pending. A read of that register returns the multiplier in force in [7:0] and the constant 0x02C000 in [31:8], and the multiplier output does not change.
- R6: Writing the control register at offset 0x0C with bit 3 set requests a soft reset. Writing it with bit 3 clear does nothing. The register always reads 0.
- R7: A soft-reset request raises the soft-reset output one clock later, for exactly 16 cycles. The pending multiplier goes into force at the edge that raises the pulse.
- R8: The push-button input passes through a two-flop synchroniser. Only a high-to-low transition requests a soft reset, with the pulse visible after the third clock edge that follows the change. Holding the button low does not retrigger.
- R9: A request that arrives while the pulse is high is dropped and does not lengthen the pulse.
- R10: If an oscillator write lands in the same cycle as a pulse start, the value that was pending before that cycle goes into force. The newly written value stays pending for the next soft reset.
- R11: Unmapped offsets read 0, and the read data is 0 whenever the bus select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_en | input | 1 | Bus select for this slave |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| btn_n | input | 1 | Asynchronous push-button, active low |
| osc_vdw | output | 8 | Multiplier field in force |
| osc_rdw | output | 7 | Fixed reference-divider field |
| osc_od | output | 3 | Fixed output-divider code |
| soft_rst | output | 1 | Soft-reset pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an oscillator write and the start of a pulse: the bench drives the button low and then places an oscillator write exactly on the edge where the synchronised falling edge starts the pulse. The second pair is a new request and a pulse already in progress: a control-register trigger is written a few cycles into a running pulse. A behavioural model is updated every clock and compared at every falling edge against the multiplier output, the soft-reset output and the read data. Directed checks confirm that the older pending value went into force, that the new value is picked up by the next soft reset, and that the pulse stays exactly 16 cycles long.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W = 32;
  localparam int VDW_W  = 8;
  localparam int RDW_W  = 7;
  localparam int OD_W   = 3;
  localparam int KEY_W  = 16;

  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [VDW_W-1:0] VDW_POR    = 8'h20;
  localparam logic [RDW_W-1:0] RDW_FIXED  = 7'h16;
  localparam logic [OD_W-1:0]  OD_FIXED   = 3'b001;

  localparam logic [7:0] OFF_OSC  = 8'h08;
  localparam logic [7:0] OFF_CTRL = 8'h0C;
  localparam logic [7:0] OFF_LOCK = 8'h14;
  localparam int         CTRL_SR_BIT = 3;

  typedef enum logic [1:0] {SEL_NONE, SEL_OSC, SEL_CTRL, SEL_LOCK} reg_sel_e;

  function automatic logic key_opens(input logic [KEY_W-1:0] w);
    return w == UNLOCK_KEY;
  endfunction

  function automatic logic [DATA_W-1:0] lock_word(input logic locked,
                                                 input logic [KEY_W-1:0] lo);
    return {{(DATA_W-KEY_W-1){1'b0}}, locked, lo};
  endfunction

  function automatic logic [DATA_W-1:0] osc_word(input logic [DATA_W-VDW_W-1:0] hi,
                                                input logic [VDW_W-1:0] v);
    return {hi, v};
  endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              wr_osc,
  output logic              wr_ctrl,
  output logic              wr_lock
);
  localparam logic [ADDR_W-1:0] A_OSC  = OFF_OSC[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL = OFF_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_LOCK = OFF_LOCK[ADDR_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (en) begin
      unique case (addr)
        A_OSC:   sel = SEL_OSC;
        A_CTRL:  sel = SEL_CTRL;
        A_LOCK:  sel = SEL_LOCK;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign wr_osc  = wr && (sel == SEL_OSC);
  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign wr_lock = wr && (sel == SEL_LOCK);
endmodule

// File: rtl/clkctl_btn_sync.sv
module clkctl_btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic press
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], btn_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign press = last_q && !sync_q[STAGES-1];
endmodule

// File: rtl/clkctl_pulse.sv
module clkctl_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start,
  output logic pulse
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  assign start = req && (cnt_q == '0);
  assign pulse = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/clkctl_osc_store.sv
module clkctl_osc_store
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_osc,
  input  logic             wr_lock,
  input  logic [KEY_W-1:0] key_in,
  input  logic [VDW_W-1:0] vdw_in,
  input  logic             apply,
  output logic             locked,
  output logic [KEY_W-1:0] lock_lo,
  output logic [VDW_W-1:0] pend_vdw,
  output logic [VDW_W-1:0] act_vdw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b1;
      lock_lo <= '0;
    end else if (wr_lock) begin
      locked  <= !key_opens(key_in);
      lock_lo <= key_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_vdw <= VDW_POR;
    else if (wr_osc && !locked) pend_vdw <= vdw_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act_vdw <= VDW_POR;
    else if (apply) act_vdw <= pend_vdw;
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter int                PULSE_LEN = 16,
  parameter logic [23:0]       OSC_HI    = 24'h02C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              btn_n,
  output logic [7:0]        osc_vdw,
  output logic [6:0]        osc_rdw,
  output logic [2:0]        osc_od,
  output logic              soft_rst
);
  reg_sel_e         sel;
  logic             ev_osc_wr, ev_ctrl_wr, ev_lock_wr;
  logic             ev_btn_press, ev_ctrl_trig, ev_sr_req, ev_sr_start;
  logic             lock_state;
  logic [KEY_W-1:0] lock_lo;
  logic [VDW_W-1:0] pend_vdw;
  logic             unused_ok;

  clkctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en(bus_en), .wr(bus_wr), .addr(bus_addr), .sel(sel),
    .wr_osc(ev_osc_wr), .wr_ctrl(ev_ctrl_wr), .wr_lock(ev_lock_wr)
  );

  clkctl_btn_sync #(.STAGES(2)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .press(ev_btn_press)
  );

  assign ev_ctrl_trig = ev_ctrl_wr && bus_wdata[CTRL_SR_BIT];
  assign ev_sr_req    = ev_ctrl_trig || ev_btn_press;

  clkctl_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .req(ev_sr_req), .start(ev_sr_start), .pulse(soft_rst)
  );

  clkctl_osc_store u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_osc(ev_osc_wr), .wr_lock(ev_lock_wr),
    .key_in(bus_wdata[KEY_W-1:0]), .vdw_in(bus_wdata[VDW_W-1:0]),
    .apply(ev_sr_start),
    .locked(lock_state), .lock_lo(lock_lo),
    .pend_vdw(pend_vdw), .act_vdw(osc_vdw)
  );

  assign osc_rdw = RDW_FIXED;
  assign osc_od  = OD_FIXED;

  always_comb begin
    unique case (sel)
      SEL_OSC:  bus_rdata = osc_word(OSC_HI, osc_vdw);
      SEL_LOCK: bus_rdata = lock_word(lock_state, lock_lo);
      default:  bus_rdata = '0;
    endcase
  end

  assign unused_ok = ^bus_wdata[31:KEY_W];
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk #(
  parameter int ADDR_W    = 5,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [7:0]        osc_vdw,
  input logic [6:0]        osc_rdw,
  input logic [2:0]        osc_od,
  input logic              ev_sr_start,
  input logic              ev_osc_wr,
  input logic              ev_lock_wr,
  input logic              lock_state,
  input logic [7:0]        pend_vdw,
  input logic [31:0]       bus_wdata
);
  localparam int HC_W = $clog2(PULSE_LEN + 1) + 1;
  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (soft_rst) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  assert_fixed_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rdw == 7'h16 && osc_od == 3'b001);

  assert_unlock_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lock_wr && bus_wdata[15:0] == 16'hA05F) |=> !lock_state);

  assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lock_wr && bus_wdata[15:0] != 16'hA05F) |=> lock_state);

  assert_locked_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_osc_wr && lock_state) |=> $stable(pend_vdw));

  assert_vdw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sr_start |=> $stable(osc_vdw));

  assert_start_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sr_start |=> (osc_vdw == $past(pend_vdw) && soft_rst));

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> hi_cnt == HC_W'(PULSE_LEN));

  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sr_start |-> !soft_rst);
endmodule

bind clkctl_regs clkctl_regs_chk #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .osc_vdw(osc_vdw),
  .osc_rdw(osc_rdw), .osc_od(osc_od), .ev_sr_start(ev_sr_start),
  .ev_osc_wr(ev_osc_wr), .ev_lock_wr(ev_lock_wr), .lock_state(lock_state),
  .pend_vdw(pend_vdw), .bus_wdata(bus_wdata)
);

// File: tb/clkctl_regs_bench.sv
`timescale 1ns/1ps
module clkctl_regs_bench;
  localparam int AW = 5;
  localparam logic [23:0] HI = 24'h02C000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0, btn_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] osc_vdw;
  logic [6:0] osc_rdw;
  logic [2:0] osc_od;
  logic soft_rst;

  int checks = 0, errors = 0, hi_total = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  clkctl_regs u_clkctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .btn_n(btn_n), .osc_vdw(osc_vdw), .osc_rdw(osc_rdw), .osc_od(osc_od),
    .soft_rst(soft_rst)
  );

  // behavioural reference model
  int   m_pend, m_act, m_lo, m_cnt;
  bit   m_locked;
  bit   m_hist[$];   // button samples, oldest first

  function automatic logic [31:0] exp_rd();
    if (!bus_en) return 32'h0;
    case (int'(bus_addr))
      8:  return {HI, 8'(m_act)};
      20: return {15'h0, m_locked, 16'(m_lo)};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 32; m_act = 32; m_lo = 0; m_cnt = 0; m_locked = 1;
      m_hist = '{1, 1, 1};
    end else begin
      bit fell, req;
      int old_pend;
      fell = m_hist[0] && !m_hist[1];
      m_hist.pop_front();
      m_hist.push_back(btn_n);
      old_pend = m_pend;
      req = fell || (bus_en && bus_wr && int'(bus_addr) == 12 && bus_wdata[3]);
      if (bus_en && bus_wr && int'(bus_addr) == 8 && !m_locked) m_pend = bus_wdata[7:0];
      if (bus_en && bus_wr && int'(bus_addr) == 20) begin
        m_lo = bus_wdata[15:0];
        m_locked = (bus_wdata[15:0] != 16'hA05F);
      end
      if (req && m_cnt == 0) begin m_act = old_pend; m_cnt = 16; end
      else if (m_cnt > 0) m_cnt--;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (soft_rst) hi_total++;
      chk("R7 pulse", {31'h0, soft_rst}, {31'h0, m_cnt > 0});
      chk("R7 vdw", {24'h0, osc_vdw}, 32'(m_act));
      chk("R11 rdata", bus_rdata, exp_rd());
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_en = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_en = 1; bus_wr = 0; bus_addr = AW'(a);
    #2 d = bus_rdata;
    @(negedge clk); #1;
    bus_en = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    settle(1);
    chk("R1 vdw", {24'h0, osc_vdw}, 32'h20);
    chk("R1 sr", {31'h0, soft_rst}, 32'h0);
    chk("R2 rdw", {25'h0, osc_rdw}, 32'h16);
    chk("R2 od", {29'h0, osc_od}, 32'h1);
    bus_read(20, rd); chk("R1 lock", rd, 32'h0001_0000);

    // locked write ignored
    bus_write(8, 32'h30);
    bus_write(12, 32'h8);
    settle(20);
    chk("R4 locked", {24'h0, osc_vdw}, 32'h20);

    bus_write(20, 32'hFFFF_1234); bus_read(20, rd); chk("R3 wrong key", rd, 32'h0001_1234);
    bus_write(20, 32'h0000_A05F); bus_read(20, rd); chk("R3 key", rd, 32'h0000_A05F);

    bus_write(8, 32'hFFFF_FF13);
    bus_read(8, rd); chk("R5 readback", rd, {HI, 8'h20});
    chk("R5 out", {24'h0, osc_vdw}, 32'h20);

    bus_write(12, 32'h7);
    settle(5);
    chk("R6 no trig", {31'h0, soft_rst}, 32'h0);
    bus_read(12, rd); chk("R6 read0", rd, 32'h0);

    hi_total = 0;
    bus_write(12, 32'h8);
    chk("R7 rise", {31'h0, soft_rst}, 32'h1);
    chk("R7 apply", {24'h0, osc_vdw}, 32'h13);
    settle(3);
    bus_write(12, 32'h8);
    settle(30);
    chk("R7 len", 32'(hi_total), 32'd16);
    chk("R9 no extend", 32'(hi_total), 32'd16);

    // button press
    bus_write(8, 32'h30);
    #0 btn_n = 0;
    settle(1); chk("R8 e1", {31'h0, soft_rst}, 32'h0);
    settle(1); chk("R8 e2", {31'h0, soft_rst}, 32'h0);
    settle(1); chk("R8 e3", {31'h0, soft_rst}, 32'h1);
    chk("R8 apply", {24'h0, osc_vdw}, 32'h30);
    hi_total = 0;
    settle(40);
    chk("R8 held", 32'(hi_total), 32'd15);
    btn_n = 1;
    settle(5);

    // collision: oscillator write on the start edge
    btn_n = 0;
    @(negedge clk);
    bus_write(8, 32'h28);
    chk("R10 start", {31'h0, soft_rst}, 32'h1);
    chk("R10 old", {24'h0, osc_vdw}, 32'h30);
    settle(25);
    btn_n = 1;
    settle(5);
    bus_write(12, 32'h8);
    chk("R10 next", {24'h0, osc_vdw}, 32'h28);
    settle(20);

    // relock then write
    bus_write(20, 32'h0);
    bus_write(8, 32'h55);
    bus_write(12, 32'h8);
    settle(20);
    chk("R4 relock", {24'h0, osc_vdw}, 32'h28);

    bus_read(0, rd);  chk("R11 off0", rd, 32'h0);
    bus_read(28, rd); chk("R11 off1c", rd, 32'h0);
    @(negedge clk); #1 bus_addr = AW'(8); #2;
    chk("R11 no sel", bus_rdata, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule